// File: doc/BRIEF.md
# Coprocessor Exception Signaling Unit

This unit sits between a numeric coprocessor's arithmetic core and the main processor and handles exception reporting for both sides. Each completed operation can raise up to six exception flags. The unit keeps only the most urgent flag from each operation. It then checks that flag against a six-bit mask held in its control register:

- **Masked exception:** the unit sets the sticky status bit and pulses a fix-up request, so the core applies its default repair and carries on.
- **Unmasked exception:** the unit sets the sticky status bit, raises an error line toward the processor, and freezes a snapshot of the context at the moment of the fault. The snapshot holds the control mask, the status bits, the tag word, and the instruction and operand pointers.

The processor side reports lazily. The error line is only looked at when an escape or wait instruction is decoded. If the line is high at that point, the unit issues a one-cycle trap request that carries vector 16. If the line is low, the instruction is released with a one-cycle go pulse instead. A handler ends the episode with the clear command, which empties the status bits and drops the error line.

Top module: `cx_fault_signal`

## Requirements
- R1: After reset, the status bits, error line, fix-up, trap, go and snapshot outputs are all zero, and the mask reads all ones (every exception masked).
- R2: Status bits are laid out as: bit 0 invalid, bit 1 denormal, bit 2 zero-divide, bit 3 overflow, bit 4 underflow, bit 5 precision. Only the lowest-numbered raised flag of an operation is recorded, one cycle after `op_valid_i`. For example, invalid together with zero-divide records invalid alone.
- R3: When the recorded flag is masked (mask bit 1), `fix_o` pulses that one bit for exactly one cycle and the error line stays low. A mask written in the same cycle as the operation applies to it.
- R4: When the recorded flag is unmasked (mask bit 0), `err_o` is high one cycle after the operation.
- R5: Status bits are sticky. Later operations with no flags leave them set.
- R6: `clr_i` zeroes the status bits and lowers `err_o` on the next cycle. If an operation arrives in the same cycle, its flag is recorded after the clear.
- R7: An escape or wait decode while `err_o` is high gives `trap_o` high for exactly one cycle, one cycle later, with `trap_vec_o` = 16. Every such decode gives its own pulse.
- R8: An escape or wait decode while `err_o` is low gives a one-cycle `go_o` pulse one cycle later and no trap.
- R9: When `err_o` rises, the snapshot captures the mask, the status bits, `tag_i`, `iptr_i` and `optr_i` from that operation's cycle. Later operations do not alter the snapshot until the next clear.
- R10: `err_o` always equals the OR of the status bits whose mask bit is 0, one cycle after any mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation completed; flags valid |
| op_flags_i | input | 6 | Raised exception flags (R2 layout) |
| ctl_we_i | input | 1 | Write the mask register |
| ctl_mask_i | input | 6 | New mask value; 1 = masked |
| clr_i | input | 1 | Clear-exceptions command |
| tag_i | input | TAG_W | Current tag word |
| iptr_i | input | PTR_W | Current instruction pointer |
| optr_i | input | PTR_W | Current operand pointer |
| esc_dec_i | input | 1 | Escape instruction decoded |
| wait_dec_i | input | 1 | Wait instruction decoded |
| status_o | output | 6 | Sticky status bits |
| mask_o | output | 6 | Current mask register |
| err_o | output | 1 | Error line to the processor |
| fix_o | output | 6 | One-cycle fix-up request |
| trap_o | output | 1 | One-cycle trap request |
| trap_vec_o | output | 8 | Trap vector (16 with trap) |
| go_o | output | 1 | One-cycle instruction release |
| snap_ctl_o | output | 6 | Snapshot of the mask |
| snap_stat_o | output | 6 | Snapshot of the status bits |
| snap_tag_o | output | TAG_W | Snapshot of the tag word |
| snap_iptr_o | output | PTR_W | Snapshot of the instruction pointer |
| snap_optr_o | output | PTR_W | Snapshot of the operand pointer |

## Verification
Every result of the unit comes from a single register stage:

- Status bits, error line, fix-up and snapshot follow the operation, mask write or clear by one clock edge.
- Trap, vector and go follow the decode by one edge.

The bench drives inputs on the falling edge and samples on the falling edge after the next rising edge, so each check reads the value produced by exactly one sampling edge. The pulse checks take a second sample one cycle later to confirm the output has returned low.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
  localparam int EXC_N = 6;
  typedef enum logic [2:0] {
    EXC_INVALID = 3'd0,
    EXC_DENORM  = 3'd1,
    EXC_ZDIV    = 3'd2,
    EXC_OVF     = 3'd3,
    EXC_UNF     = 3'd4,
    EXC_PREC    = 3'd5
  } exc_idx_e;
  typedef logic [EXC_N-1:0] exc_vec_t;
endpackage

// File: rtl/cxf_prio_pick.sv
module cxf_prio_pick
  import cxf_pkg::*;
(
  input  logic     en_i,
  input  exc_vec_t flags_i,
  output exc_vec_t pick_o
);
  exc_vec_t raw;

  // lowest index wins: invalid first, precision last
  genvar i;
  generate
    for (i = 0; i < EXC_N; i++) begin : g_pick
      if (i == 0) begin : g_first
        assign raw[i] = flags_i[i];
      end else begin : g_rest
        assign raw[i] = flags_i[i] & ~(|flags_i[i-1:0]);
      end
    end
  endgenerate

  assign pick_o = en_i ? raw : '0;

  always_comb begin
    a_pick_onehot_r2: assert ($onehot0(pick_o));
  end
endmodule

// File: rtl/cxf_status_core.sv
module cxf_status_core
  import cxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  exc_vec_t pick_i,
  input  logic     ctl_we_i,
  input  exc_vec_t ctl_mask_i,
  input  logic     clr_i,
  output exc_vec_t status_o,
  output exc_vec_t mask_o,
  output logic     err_o,
  output exc_vec_t fix_o,
  output logic     cap_o,
  output exc_vec_t stat_next_o,
  output exc_vec_t mask_next_o
);
  exc_vec_t stat_q, mask_q, fix_q;
  exc_vec_t stat_d, mask_d, fix_d;
  logic     err_q, err_d;

  always_comb begin
    mask_d = ctl_we_i ? ctl_mask_i : mask_q;
    stat_d = (clr_i ? '0 : stat_q) | pick_i;
    err_d  = |(stat_d & ~mask_d);
    fix_d  = pick_i & mask_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      err_q  <= 1'b0;
      fix_q  <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      err_q  <= err_d;
      fix_q  <= fix_d;
    end
  end

  assign status_o    = stat_q;
  assign mask_o      = mask_q;
  assign err_o       = err_q;
  assign fix_o       = fix_q;
  assign cap_o       = err_d & (~err_q | clr_i);
  assign stat_next_o = stat_d;
  assign mask_next_o = mask_d;

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_one_new_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ($countones(stat_q & ~$past(stat_q)) <= 1));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && pick_i == '0) |=> (stat_q == '0 && !err_q));
  p_fix_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fix_q));
  p_fix_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (fix_q != '0) |-> ((fix_q & ~mask_q) == '0));
endmodule

// File: rtl/cxf_env_snap.sv
module cxf_env_snap
  import cxf_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic             clr_i,
  input  exc_vec_t         ctl_i,
  input  exc_vec_t         stat_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PTR_W-1:0] iptr_i,
  input  logic [PTR_W-1:0] optr_i,
  output exc_vec_t         ctl_o,
  output exc_vec_t         stat_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [PTR_W-1:0] iptr_o,
  output logic [PTR_W-1:0] optr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o  <= '0;
      stat_o <= '0;
      tag_o  <= '0;
      iptr_o <= '0;
      optr_o <= '0;
    end else if (cap_i) begin
      ctl_o  <= ctl_i;
      stat_o <= stat_i;
      tag_o  <= tag_i;
      iptr_o <= iptr_i;
      optr_o <= optr_i;
    end else if (clr_i) begin
      ctl_o  <= '0;
      stat_o <= '0;
      tag_o  <= '0;
      iptr_o <= '0;
      optr_o <= '0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cap_i && !clr_i) |=> ($stable(iptr_o) && $stable(optr_o) &&
                            $stable(tag_o) && $stable(stat_o) && $stable(ctl_o)));
endmodule

// File: rtl/cxf_trap_gate.sv
module cxf_trap_gate #(
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             esc_dec_i,
  input  logic             wait_dec_i,
  input  logic             err_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             go_o
);
  localparam logic [VEC_W-1:0] VecVal = VEC_W'(TRAP_VEC);
  logic dec;
  assign dec = esc_dec_i | wait_dec_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o <= 1'b0;
      vec_o  <= '0;
      go_o   <= 1'b0;
    end else begin
      trap_o <= dec & err_i;
      vec_o  <= (dec & err_i) ? VecVal : '0;
      go_o   <= dec & ~err_i;
    end
  end

  p_trap_req_r7: assert property (@(posedge clk) disable iff (rst)
    (dec && err_i) |=> (trap_o && vec_o == VecVal && !go_o));
  p_no_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (dec && !err_i) |=> (go_o && !trap_o));
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !dec |=> (!trap_o && !go_o));
endmodule

// File: rtl/cx_fault_signal.sv
module cx_fault_signal
  import cxf_pkg::*;
#(
  parameter int TAG_W    = 16,
  parameter int PTR_W    = 32,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid_i,
  input  logic [5:0]       op_flags_i,
  input  logic             ctl_we_i,
  input  logic [5:0]       ctl_mask_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PTR_W-1:0] iptr_i,
  input  logic [PTR_W-1:0] optr_i,
  input  logic             esc_dec_i,
  input  logic             wait_dec_i,
  output logic [5:0]       status_o,
  output logic [5:0]       mask_o,
  output logic             err_o,
  output logic [5:0]       fix_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             go_o,
  output logic [5:0]       snap_ctl_o,
  output logic [5:0]       snap_stat_o,
  output logic [TAG_W-1:0] snap_tag_o,
  output logic [PTR_W-1:0] snap_iptr_o,
  output logic [PTR_W-1:0] snap_optr_o
);
  exc_vec_t pick, stat_next, mask_next;
  logic     cap;

  cxf_prio_pick u_pick (
    .en_i   (op_valid_i),
    .flags_i(op_flags_i),
    .pick_o (pick)
  );

  cxf_status_core u_core (
    .clk        (clk),
    .rst        (rst),
    .pick_i     (pick),
    .ctl_we_i   (ctl_we_i),
    .ctl_mask_i (ctl_mask_i),
    .clr_i      (clr_i),
    .status_o   (status_o),
    .mask_o     (mask_o),
    .err_o      (err_o),
    .fix_o      (fix_o),
    .cap_o      (cap),
    .stat_next_o(stat_next),
    .mask_next_o(mask_next)
  );

  cxf_env_snap #(.TAG_W(TAG_W), .PTR_W(PTR_W)) u_snap (
    .clk   (clk),
    .rst   (rst),
    .cap_i (cap),
    .clr_i (clr_i),
    .ctl_i (mask_next),
    .stat_i(stat_next),
    .tag_i (tag_i),
    .iptr_i(iptr_i),
    .optr_i(optr_i),
    .ctl_o (snap_ctl_o),
    .stat_o(snap_stat_o),
    .tag_o (snap_tag_o),
    .iptr_o(snap_iptr_o),
    .optr_o(snap_optr_o)
  );

  cxf_trap_gate #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .esc_dec_i (esc_dec_i),
    .wait_dec_i(wait_dec_i),
    .err_i     (err_o),
    .trap_o    (trap_o),
    .vec_o     (trap_vec_o),
    .go_o      (go_o)
  );

  p_err_summary_r10: assert property (@(posedge clk) disable iff (rst)
    err_o == |(status_o & ~mask_o));
  p_err_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && ((pick & ~mask_next) != '0)) |=> err_o);
endmodule

// File: tb/cx_fault_signal_tb.sv
module cx_fault_signal_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid_i = 0, ctl_we_i = 0, clr_i = 0, esc_dec_i = 0, wait_dec_i = 0;
  logic [5:0] op_flags_i = 0, ctl_mask_i = 0;
  logic [15:0] tag_i = 0;
  logic [31:0] iptr_i = 0, optr_i = 0;
  logic [5:0] status_o, mask_o, fix_o, snap_ctl_o, snap_stat_o;
  logic err_o, trap_o, go_o;
  logic [7:0] trap_vec_o;
  logic [15:0] snap_tag_o;
  logic [31:0] snap_iptr_o, snap_optr_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cx_fault_signal dut_i (.*);

  // {mask[24:19], flags[18:13], status[12:7], err[6], fix[5:0]}
  localparam logic [24:0] VECS [7] = '{
    {6'h3F, 6'h05, 6'h01, 1'b0, 6'h01},
    {6'h3E, 6'h05, 6'h01, 1'b1, 6'h00},
    {6'h3F, 6'h30, 6'h10, 1'b0, 6'h10},
    {6'h37, 6'h38, 6'h08, 1'b1, 6'h00},
    {6'h00, 6'h20, 6'h20, 1'b1, 6'h00},
    {6'h3D, 6'h06, 6'h02, 1'b1, 6'h00},
    {6'h00, 6'h00, 6'h00, 1'b0, 6'h00}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    op_valid_i = 0; ctl_we_i = 0; clr_i = 0; esc_dec_i = 0; wait_dec_i = 0;
    op_flags_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", status_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 mask", mask_o, 6'h3F);
    chk("R1 trap/go/fix", {trap_o, go_o, fix_o}, 0);
    chk("R1 snapshot", snap_iptr_o, 0);

    // table walk: R2 R3 R4
    for (int k = 0; k < 7; k++) begin
      clr_i = 1; ctl_we_i = 1; ctl_mask_i = VECS[k][24:19];
      step();
      idle();
      op_valid_i = 1; op_flags_i = VECS[k][18:13];
      step();
      idle();
      chk("R2 status", status_o, VECS[k][12:7]);
      chk("R4 err", err_o, VECS[k][6]);
      chk("R3 fix", fix_o, VECS[k][5:0]);
      step();
      chk("R3 fix pulse ends", fix_o, 0);
    end

    // R5 sticky + R7 traps (state: denormal unmasked set from last error vector? clear first)
    clr_i = 1; ctl_we_i = 1; ctl_mask_i = 6'h3E;
    step(); idle();
    op_valid_i = 1; op_flags_i = 6'h01;
    step(); idle();
    op_valid_i = 1; op_flags_i = 6'h00;
    step(); idle();
    chk("R5 sticky status", status_o, 6'h01);
    chk("R5 sticky err", err_o, 1);
    esc_dec_i = 1;
    step(); idle();
    chk("R7 trap on escape", trap_o, 1);
    chk("R7 vector", trap_vec_o, 16);
    chk("R8 no go with error", go_o, 0);
    step();
    chk("R7 single pulse", trap_o, 0);
    wait_dec_i = 1;
    step(); idle();
    chk("R7 trap on wait", {trap_o, trap_vec_o}, {1'b1, 8'd16});

    // R6 clear, then R8 go
    clr_i = 1;
    step(); idle();
    chk("R6 status cleared", status_o, 0);
    chk("R6 err cleared", err_o, 0);
    esc_dec_i = 1;
    step(); idle();
    chk("R8 go", {go_o, trap_o}, 2'b10);
    step();
    chk("R8 go single pulse", go_o, 0);

    // R6 clear with op in same cycle
    op_valid_i = 1; op_flags_i = 6'h01; clr_i = 1;
    step(); idle();
    chk("R6 op after clear", {status_o, err_o}, {6'h01, 1'b1});

    // R9 snapshot
    clr_i = 1;
    step(); idle();
    tag_i = 16'h1234; iptr_i = 32'h1000; optr_i = 32'h2000;
    op_valid_i = 1; op_flags_i = 6'h01;
    step(); idle();
    tag_i = 16'hBEEF; iptr_i = 32'h5555; optr_i = 32'h6666;
    chk("R9 snap iptr", snap_iptr_o, 32'h1000);
    chk("R9 snap optr", snap_optr_o, 32'h2000);
    chk("R9 snap tag", snap_tag_o, 16'h1234);
    chk("R9 snap ctl/stat", {snap_ctl_o, snap_stat_o}, {6'h3E, 6'h01});
    op_valid_i = 1; op_flags_i = 6'h08;
    step(); idle();
    esc_dec_i = 1;
    step(); idle();
    chk("R9 status still updates", status_o, 6'h09);
    chk("R9 snap held iptr", snap_iptr_o, 32'h1000);
    chk("R9 snap held stat", snap_stat_o, 6'h01);

    // R10 mask write raises the line
    clr_i = 1; ctl_we_i = 1; ctl_mask_i = 6'h3F;
    step(); idle();
    op_valid_i = 1; op_flags_i = 6'h20;
    step(); idle();
    chk("R10 masked no err", err_o, 0);
    ctl_we_i = 1; ctl_mask_i = 6'h1F;
    step(); idle();
    chk("R10 err after unmask", err_o, 1);
    ctl_we_i = 1; ctl_mask_i = 6'h3F;
    step(); idle();
    chk("R10 err after remask", err_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule